// File: doc/BRIEF.md
# Periodic Timer and Interrupt Controller

This peripheral gives a small 32-bit processor a time base and a single interrupt request line. A free-running counter advances on every clock. Two chosen counter bits each produce a pair of level sources: one is high while the bit is set and the other is high while it is clear. Software gets an interrupt on each edge of a counter bit by unmasking one member of the pair, servicing it, and then swapping the two mask bits. Each compare channel holds a target value. It latches a pending flag when the counter passes through that value, and the flag stays set until software writes the compare register again.

Every source is ANDed with its bit of a mask register. The results are ORed together, gated by a global enable bit, and registered once to drive the interrupt line. Software reaches the block over a request/response register port with valid/ready on both halves. The block takes a request only when it has room to present the response. A response, once valid, holds its data unchanged until the requester takes it. Every request gets exactly one response: a read returns the register, and a write returns zero.

Register word addresses: 0 counter (read only), 1 raw source status (read only), 2 mask, 3 global enable (bit 0), and 4+i compare channel i. Source bit positions, shared by status and mask: bit 0 = high counter bit set, bit 1 = high counter bit clear, bit 2 = low counter bit set, bit 3 = low counter bit clear, bit 4+i = compare i pending.

Top module: `tic_timer_irq`

## Requirements
- R1: The counter is 0 in reset and grows by one on every clock. A read of address 0 returns the counter value present in the cycle the request is accepted.
- R2: Status bit 0 equals counter bit HI_BIT and bit 1 is its complement. Bit 2 equals counter bit LO_BIT and bit 3 is its complement. All four are sampled in the cycle the read is accepted.
- R3: Each compare register resets to all ones and reads back the last value written at address 4+i.
- R4: When the counter equals compare i in a cycle, pending bit 4+i is set from the next cycle on.
- R5: A pending compare flag stays set, whatever the counter does, until its compare register is written.
- R6: A write to compare i clears only pending bit 4+i, even when a match occurs in the same cycle. The other channel's flag is unaffected.
- R7: The mask register at address 2 holds 4+NUM_CMP bits. It resets to 0, and higher write-data bits are dropped.
- R8: The global enable at address 3, bit 0, resets to 0. While it is 0 the interrupt output stays low whatever the sources and mask are.
- R9: The interrupt output equals, one clock later, the global enable ANDed with the OR of (status AND mask).
- R10: req_ready is high exactly when no response is held or rsp_ready is high. A held response keeps rsp_valid high and rsp_rdata stable until taken.
- R11: Writes to addresses 0, 1 and unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R12: Reset clears the mask, the global enable and all pending compare flags, and drives the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
The bench builds the block with HI_BIT = 6 and LO_BIT = 4, so the two source pairs swap every 64 and 16 cycles. This puts many edges of both periodic sources within a few hundred cycles, and lets the bench predict each status and interrupt value from a cycle count. NUM_CMP stays at 2, which allows checks that clearing one compare flag leaves the other one set. The counter stays 32 bits wide, so compare targets are ordinary 32-bit values a few dozen cycles ahead of the current count.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int ADDR_W       = 4;
  localparam int ADR_COUNT    = 0;
  localparam int ADR_STATUS   = 1;
  localparam int ADR_MASK     = 2;
  localparam int ADR_ENABLE   = 3;
  localparam int ADR_CMP_BASE = 4;

  localparam int SRC_HI_SET   = 0;
  localparam int SRC_HI_CLR   = 1;
  localparam int SRC_LO_SET   = 2;
  localparam int SRC_LO_CLR   = 3;
  localparam int SRC_PERIODIC = 4;
endpackage

// File: rtl/tic_counter.sv
module tic_counter #(
  parameter int W      = 32,
  parameter int HI_BIT = 18,
  parameter int LO_BIT = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  output logic [W-1:0]                      cnt_o,
  output logic [tic_pkg::SRC_PERIODIC-1:0]  per_src_o
);
  import tic_pkg::*;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + W'(1);
  end

  always_comb begin
    per_src_o             = '0;
    per_src_o[SRC_HI_SET] = cnt_q[HI_BIT];
    per_src_o[SRC_HI_CLR] = ~cnt_q[HI_BIT];
    per_src_o[SRC_LO_SET] = cnt_q[LO_BIT];
    per_src_o[SRC_LO_CLR] = ~cnt_q[LO_BIT];
  end

  assign cnt_o = cnt_q;

  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  // R1: counter advances by exactly one per clock once running
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/tic_compare.sv
module tic_compare #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o,
  output logic         pend_o
);
  logic [W-1:0] cmp_q;
  logic         pend_q;
  logic         hit;

  assign hit = (cnt_i == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      cmp_q  <= wdata_i;
      pend_q <= 1'b0;
    end else if (hit) begin
      pend_q <= 1'b1;
    end
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  // R4: a match without a write latches the flag
  a_r4_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_i) |=> pend_q);
  // R5: flag stays set until the register is written
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_i) |=> pend_q);
  // R6: a write always clears the flag
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !pend_q);
endmodule

// File: rtl/tic_irq_gate.sv
module tic_irq_gate #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            gie_i,
  output logic            irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gie_i & (|(src_i & mask_i));
  end

  assign irq_o = irq_q;

  // R8: global enable low blocks the request on the next cycle
  a_r8_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_q);
  // R9: no request without an unmasked active source one cycle earlier
  a_r9_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & mask_i) == '0) |=> !irq_q);
endmodule

// File: rtl/tic_regbus.sv
module tic_regbus #(
  parameter int W       = 32,
  parameter int NUM_CMP = 2,
  parameter int NSRC    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic [tic_pkg::ADDR_W-1:0]  req_addr_i,
  input  logic [W-1:0]                req_wdata_i,
  output logic                        rsp_valid_o,
  input  logic                        rsp_ready_i,
  output logic [W-1:0]                rsp_rdata_o,
  input  logic [W-1:0]                cnt_i,
  input  logic [NSRC-1:0]             src_i,
  input  logic [NUM_CMP-1:0][W-1:0]   cmp_i,
  output logic [NUM_CMP-1:0]          cmp_we_o,
  output logic [NSRC-1:0]             mask_o,
  output logic                        gie_o
);
  import tic_pkg::*;

  logic            rsp_valid_q;
  logic [W-1:0]    rsp_rdata_q;
  logic [NSRC-1:0] mask_q;
  logic            gie_q;
  logic            accept;
  logic            wr_acc;
  logic [W-1:0]    rd_val;

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign wr_acc      = accept && req_write_i;

  always_comb begin
    rd_val = '0;
    case (req_addr_i)
      ADDR_W'(ADR_COUNT):  rd_val = cnt_i;
      ADDR_W'(ADR_STATUS): rd_val[NSRC-1:0] = src_i;
      ADDR_W'(ADR_MASK):   rd_val[NSRC-1:0] = mask_q;
      ADDR_W'(ADR_ENABLE): rd_val[0] = gie_q;
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (req_addr_i == ADDR_W'(ADR_CMP_BASE + i)) rd_val = cmp_i[i];
      end
    endcase
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_we
    assign cmp_we_o[g] = wr_acc && (req_addr_i == ADDR_W'(ADR_CMP_BASE + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else if (wr_acc) begin
      if (req_addr_i == ADDR_W'(ADR_MASK))   mask_q <= req_wdata_i[NSRC-1:0];
      if (req_addr_i == ADDR_W'(ADR_ENABLE)) gie_q  <= req_wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= req_write_i ? '0 : rd_val;
    end else if (rsp_ready_i) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign mask_o      = mask_q;
  assign gie_o       = gie_q;

  // R10: a stalled response holds valid and data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready_i) |=> (rsp_valid_q && $stable(rsp_rdata_q)));
  // R10: an accepted request always produces a response next cycle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid_q);
endmodule

// File: rtl/tic_timer_irq.sv
module tic_timer_irq #(
  parameter int W       = 32,
  parameter int HI_BIT  = 18,
  parameter int LO_BIT  = 16,
  parameter int NUM_CMP = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic [3:0]   req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_rdata,
  output logic         irq
);
  import tic_pkg::*;

  localparam int NSRC = SRC_PERIODIC + NUM_CMP;

  logic [W-1:0]              cnt;
  logic [SRC_PERIODIC-1:0]   per_src;
  logic [NUM_CMP-1:0]        pend;
  logic [NUM_CMP-1:0][W-1:0] cmp_val;
  logic [NUM_CMP-1:0]        cmp_we;
  logic [NSRC-1:0]           src;
  logic [NSRC-1:0]           mask;
  logic                      gie;

  tic_counter #(.W(W), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT)) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .per_src_o(per_src)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    tic_compare #(.W(W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .wr_i(cmp_we[g]),
      .wdata_i(req_wdata), .cmp_o(cmp_val[g]), .pend_o(pend[g])
    );
  end

  assign src = {pend, per_src};

  tic_regbus #(.W(W), .NUM_CMP(NUM_CMP), .NSRC(NSRC)) u_regbus (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .cnt_i(cnt), .src_i(src), .cmp_i(cmp_val), .cmp_we_o(cmp_we),
    .mask_o(mask), .gie_o(gie)
  );

  tic_irq_gate #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .src_i(src), .mask_i(mask), .gie_i(gie),
    .irq_o(irq)
  );
endmodule

// File: tb/tic_timer_irq_tb.sv
module tic_timer_irq_tb;
  localparam int HI = 6;
  localparam int LO = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] cyc;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 32'd1;
  end

  tic_timer_irq #(.W(32), .HI_BIT(HI), .LO_BIT(LO), .NUM_CMP(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic [31:0] acc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rd, acc;
    bus(1'b1, a, d, rd, acc);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] rd,
                        output logic [31:0] acc);
    bus(1'b0, a, '0, rd, acc);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] per_exp(input logic [31:0] c);
    return {~c[LO], c[LO], ~c[HI], c[HI]};
  endfunction

  // R12, R3, R7, R8: state after reset
  task automatic t_reset;
    logic [31:0] rd, acc;
    chk(irq == 1'b0, "R12 irq low after reset", {31'd0, irq}, 32'd0);
    rd_reg(4'd2, rd, acc); chk(rd == 32'd0, "R12 R7 mask reset", rd, 32'd0);
    rd_reg(4'd3, rd, acc); chk(rd == 32'd0, "R12 R8 enable reset", rd, 32'd0);
    rd_reg(4'd4, rd, acc); chk(rd == 32'hFFFF_FFFF, "R3 cmp0 reset", rd, 32'hFFFF_FFFF);
    rd_reg(4'd5, rd, acc); chk(rd == 32'hFFFF_FFFF, "R3 cmp1 reset", rd, 32'hFFFF_FFFF);
    rd_reg(4'd1, rd, acc); chk(rd[5:4] == 2'b00, "R12 pending clear", rd, 32'd0);
  endtask

  // R1, R11: counter reads and ignored writes
  task automatic t_counter;
    logic [31:0] rd, acc;
    rd_reg(4'd0, rd, acc); chk(rd == acc, "R1 counter read", rd, acc);
    wait_cyc(37);
    rd_reg(4'd0, rd, acc); chk(rd == acc, "R1 counter read later", rd, acc);
    wr_reg(4'd0, 32'hABCD_0000);
    rd_reg(4'd0, rd, acc); chk(rd == acc, "R11 counter write ignored", rd, acc);
  endtask

  // R2: periodic source status at several points
  task automatic t_status;
    logic [31:0] rd, acc;
    for (int k = 0; k < 8; k++) begin
      wait_cyc(3 + k * 11);
      rd_reg(4'd1, rd, acc);
      chk(rd[3:0] == per_exp(acc), "R2 periodic status", rd, {28'd0, per_exp(acc)});
    end
  endtask

  // R7, R8, R9: mask, global enable, periodic interrupts
  task automatic t_mask_gie;
    logic [31:0] rd, acc, prev;
    int bad;
    wr_reg(4'd2, 32'hFFFF_FFFF);
    rd_reg(4'd2, rd, acc); chk(rd == 32'h3F, "R7 mask width", rd, 32'h3F);
    wait_cyc(3); bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (irq) bad++;
    end
    chk(bad == 0, "R8 enable off blocks irq", bad, 0);
    rd_reg(4'd3, rd, acc); chk(rd == 32'd0, "R8 enable still 0", rd, 32'd0);
    for (int m = 0; m < 4; m++) begin
      wr_reg(4'd2, 32'd1 << m);
      wr_reg(4'd3, 32'd1);
      wait_cyc(3); bad = 0;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        prev = cyc - 32'd1;
        if (irq != per_exp(prev)[m]) bad++;
      end
      chk(bad == 0, "R9 periodic irq follows masked source", bad, 0);
    end
    wr_reg(4'd3, 32'd0);
    wait_cyc(3); bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (irq) bad++;
    end
    chk(bad == 0, "R8 enable cleared drops irq", bad, 0);
    wr_reg(4'd2, 32'd0);
  endtask

  // R4, R5, R6, R3, R9: compare channels
  task automatic t_compare;
    logic [31:0] rd, acc, tgt;
    wr_reg(4'd2, 32'h10);
    wr_reg(4'd3, 32'd1);
    rd_reg(4'd0, rd, acc);
    tgt = acc + 32'd40;
    wr_reg(4'd4, tgt);
    wr_reg(4'd5, tgt + 32'd10);
    rd_reg(4'd4, rd, acc); chk(rd == tgt, "R3 cmp0 readback", rd, tgt);
    rd_reg(4'd1, rd, acc); chk(rd[4] == 1'b0, "R4 no pending before match", rd, 32'd0);
    while (cyc < tgt + 32'd1) @(negedge clk);
    chk(irq == 1'b0, "R9 irq one cycle after pending", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk(irq == 1'b1, "R4 R9 compare irq", {31'd0, irq}, 32'd1);
    wait_cyc(100);
    rd_reg(4'd1, rd, acc);
    chk(rd[5:4] == 2'b11, "R5 both pending stay set", {30'd0, rd[5:4]}, 32'd3);
    chk(irq == 1'b1, "R5 irq held", {31'd0, irq}, 32'd1);
    wr_reg(4'd4, 32'hFFFF_0000);
    rd_reg(4'd1, rd, acc);
    chk(rd[5:4] == 2'b10, "R6 only cmp0 cleared", {30'd0, rd[5:4]}, 32'd2);
    wait_cyc(2);
    chk(irq == 1'b0, "R6 irq drops after clear", {31'd0, irq}, 32'd0);
    wr_reg(4'd5, 32'hFFFF_0000);
    rd_reg(4'd1, rd, acc);
    chk(rd[5:4] == 2'b00, "R6 cmp1 cleared", {30'd0, rd[5:4]}, 32'd0);
    wr_reg(4'd3, 32'd0);
  endtask

  // R11: read-only and unmapped addresses
  task automatic t_unmapped;
    logic [31:0] rd, acc;
    wr_reg(4'd2, 32'h15);
    wr_reg(4'd1, 32'hFFFF_FFFF);
    rd_reg(4'd2, rd, acc); chk(rd == 32'h15, "R11 status write ignored", rd, 32'h15);
    wr_reg(4'd15, 32'h1234_5678);
    rd_reg(4'd15, rd, acc); chk(rd == 32'd0, "R11 unmapped reads 0", rd, 32'd0);
    rd_reg(4'd4, rd, acc); chk(rd == 32'hFFFF_0000, "R11 cmp0 untouched", rd, 32'hFFFF_0000);
    rd_reg(4'd2, rd, acc); chk(rd == 32'h15, "R11 mask untouched", rd, 32'h15);
    rd_reg(4'd3, rd, acc); chk(rd == 32'd0, "R11 enable untouched", rd, 32'd0);
  endtask

  // R10: response back-pressure
  task automatic t_backpressure;
    logic [31:0] acc, held;
    int bad;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd0;
    chk(req_ready == 1'b1, "R10 ready when empty", {31'd0, req_ready}, 32'd1);
    acc = cyc;
    @(negedge clk);
    req_addr = 4'd2;
    chk(rsp_valid && rsp_rdata == acc, "R10 response data", rsp_rdata, acc);
    held = rsp_rdata; bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req_ready || !rsp_valid || rsp_rdata != held) bad++;
    end
    chk(bad == 0, "R10 stall holds response and blocks request", bad, 0);
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R10 ready when response taken", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_rdata == 32'h15, "R10 second response", rsp_rdata, 32'h15);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 one response per request", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_counter();
    t_status();
    t_mask_gie();
    t_compare();
    t_unmapped();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule